// File: doc/BRIEF.md
# Instruction Fetch Unit with Direct-Mapped Word Cache

This block supplies instruction words to a processor pipeline. For each fetch address it returns a 32-bit instruction, a flag saying whether that instruction is a 16-bit short encoding, or a trap. A trap is either a misaligned fetch or a translation fault. Address translation and main memory sit outside the block. The block reaches each of them through a simple request/response port. A request stays raised, with its address held steady, until the matching response arrives.

Word-aligned fetches first look in a small direct-mapped store of recently fetched words. Each stored tag is the fetch address with bit 0 forced high. Aligned addresses always have bit 0 low, so a cleared tag can never match and the forced bit acts as the valid marker. When short encodings are enabled, a fetch at an address that is 2 mod 4 is built from halfwords. The low half is translated and read first. If it is not a short encoding, the upper half comes from a separate translation of the address plus two. Halfword-assembled fetches never enter the store. A flush input and reset both clear every tag.

The controller is a single state machine with these states:
- S_IDLE: waits for a request.
- S_XL_WORD and S_RD_WORD: aligned-miss translation and word read.
- S_XL_LO and S_RD_LO: translation and read of the low half.
- S_XL_HI and S_RD_HI: translation and read of the high half.
- S_RESP: one-cycle response.

Transitions:
- From S_IDLE on an accepted request: to S_RESP on a hit or a misaligned address, to S_XL_WORD on an aligned miss, to S_XL_LO for a split fetch.
- From any translation state: to S_RESP on a fault, otherwise to the matching read state.
- From S_RD_LO: to S_RESP when the low half is a short encoding, otherwise to S_XL_HI.
- From S_RD_WORD and S_RD_HI: to S_RESP when the data arrives.
- From S_RESP: back to S_IDLE.

Top module: `insn_fetch_unit`

## Requirements
- R1: A request is taken on a clock edge where req_valid and req_ready are both high. req_ready is high only in S_IDLE while flush is low.
- R2: If req_addr[0] is 1, or req_addr[1:0] is 2'b10 with req_cmp_en low, the fetch traps as misaligned. The response comes in the cycle after acceptance with rsp_misalign=1 and rsp_insn=0, and no translation or memory request is made.
- R3: The store has 32 entries indexed by req_addr[6:2]. A hit needs req_addr[1:0]=2'b00 and a stored tag equal to {req_addr[31:1],1'b1}. A hit answers in the cycle after acceptance with the stored word and makes no translation or memory request.
- R4: An aligned miss makes exactly one translation of req_addr, then one 32-bit read (mem_req_half=0) at the translated address. rsp_insn is the word read.
- R5: A successful aligned miss writes the word and the tag {addr[31:1],1'b1} into the indexed entry. A repeat fetch then hits. A fetch of another address with the same index replaces the entry.
- R6: With req_cmp_en high and req_addr[1:0]=2'b10, the low half is translated and read as a halfword (mem_req_half=1, data in mem_resp_data[15:0]). If its bits [1:0] differ from 2'b11, rsp_insn={16'h0,low}. Otherwise addr+2 is translated and read the same way, and rsp_insn={high,low}. Such fetches never write the store.
- R7: On a successful fetch, rsp_len16 is 1 exactly when rsp_insn[1:0] differs from 2'b11. On any trap, rsp_len16 is 0.
- R8: A translation answered with xl_resp_fault=1, on either half, ends the fetch. The response has rsp_fault=1 and rsp_insn=0, no further request is made, and nothing is stored.
- R9: Reset and a flush pulse invalidate every entry. A flush while a fetch is in progress also stops that fetch from filling the store.
- R10: xl_req_valid and mem_req_valid are never both high. Each stays high with a stable address until its response. rsp_valid is a one-cycle pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| flush | input | 1 | Invalidate all stored words |
| req_valid | input | 1 | Fetch request present |
| req_ready | output | 1 | Block can take a request |
| req_addr | input | 32 | Fetch virtual address |
| req_cmp_en | input | 1 | Allow 16-bit short encodings |
| xl_req_valid | output | 1 | Translation request |
| xl_req_vaddr | output | 32 | Address to translate |
| xl_resp_valid | input | 1 | Translation answer present |
| xl_resp_paddr | input | 32 | Translated address |
| xl_resp_fault | input | 1 | Translation refused |
| mem_req_valid | output | 1 | Memory read request |
| mem_req_addr | output | 32 | Physical read address |
| mem_req_half | output | 1 | 1: halfword read, 0: word read |
| mem_resp_valid | input | 1 | Read data present |
| mem_resp_data | input | 32 | Read data (halfword in bits 15:0) |
| rsp_valid | output | 1 | Fetch result pulse |
| rsp_insn | output | 32 | Instruction word |
| rsp_len16 | output | 1 | Instruction is a short encoding |
| rsp_misalign | output | 1 | Misaligned-fetch trap |
| rsp_fault | output | 1 | Translation fault |

## Verification
Hits and misaligned traps answer exactly one cycle after the acceptance edge. The bench samples each response at the falling edge that follows and counts those edges to confirm there is no extra delay. Responses from the miss and halfword paths follow a variable number of port transactions. For these, the bench waits edge by edge for rsp_valid. It checks the result together with how many translation and memory responses were spent, which is 0, 1 or 2 of each depending on the path. The port responders answer after a random delay of 0 to 2 cycles, and every value is sampled on the falling edge, away from the edge where the design registers it.

// File: rtl/ifu_pkg.sv
package ifu_pkg;

    localparam int ILEN = 32;
    localparam int HLEN = 16;

    typedef enum logic [2:0] {
        S_IDLE,
        S_XL_WORD,
        S_RD_WORD,
        S_XL_LO,
        S_RD_LO,
        S_XL_HI,
        S_RD_HI,
        S_RESP
    } fetch_state_e;

    typedef enum logic [1:0] {
        P_WORD,
        P_SPLIT,
        P_MISALIGN
    } fetch_path_e;

    function automatic logic half_is_short(input logic [HLEN-1:0] h);
        return h[1:0] != 2'b11;
    endfunction

endpackage

// File: rtl/ifu_path_sel.sv
module ifu_path_sel
    import ifu_pkg::*;
(
    input  logic [1:0]  low_bits,
    input  logic        cmp_en,
    output fetch_path_e path
);

    always_comb begin
        unique case (low_bits)
            2'b00:   path = P_WORD;
            2'b10:   path = cmp_en ? P_SPLIT : P_MISALIGN;
            default: path = P_MISALIGN;
        endcase
    end

endmodule

// File: rtl/ifu_word_store.sv
module ifu_word_store
    import ifu_pkg::*;
#(
    parameter int AW      = 32,
    parameter int ENTRIES = 32
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            flush,
    input  logic [AW-1:0]   lk_addr,
    output logic            hit,
    output logic [ILEN-1:0] hit_data,
    input  logic            fill_en,
    input  logic [AW-1:0]   fill_addr,
    input  logic [ILEN-1:0] fill_data
);

    localparam int IDXW = $clog2(ENTRIES);

    logic [AW-1:0]   tag_q  [ENTRIES];
    logic [ILEN-1:0] data_q [ENTRIES];

    logic [IDXW-1:0] lk_idx;
    logic [IDXW-1:0] fill_idx;
    logic [AW-1:0]   lk_tag;
    logic [AW-1:0]   fill_tag;

    assign lk_idx   = lk_addr[IDXW+1:2];
    assign fill_idx = fill_addr[IDXW+1:2];
    assign lk_tag   = {lk_addr[AW-1:1], 1'b1};
    assign fill_tag = {fill_addr[AW-1:1], 1'b1};

    for (genvar e = 0; e < ENTRIES; e++) begin : g_entry
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                tag_q[e] <= '0;
            end else if (flush) begin
                tag_q[e] <= '0;
            end else if (fill_en && (fill_idx == IDXW'(e))) begin
                tag_q[e] <= fill_tag;
            end
        end

        always_ff @(posedge clk) begin
            if (fill_en && (fill_idx == IDXW'(e))) begin
                data_q[e] <= fill_data;
            end
        end
    end

    assign hit      = (lk_addr[1:0] == 2'b00) && (tag_q[lk_idx] == lk_tag);
    assign hit_data = data_q[lk_idx];

endmodule

// File: rtl/ifu_ctrl.sv
module ifu_ctrl
    import ifu_pkg::*;
#(
    parameter int AW = 32
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            flush,
    input  logic            req_valid,
    output logic            req_ready,
    input  logic [AW-1:0]   req_addr,
    input  fetch_path_e     req_path,
    input  logic            hit,
    input  logic [ILEN-1:0] hit_data,
    output logic            xl_req_valid,
    output logic [AW-1:0]   xl_req_vaddr,
    input  logic            xl_resp_valid,
    input  logic [AW-1:0]   xl_resp_paddr,
    input  logic            xl_resp_fault,
    output logic            mem_req_valid,
    output logic [AW-1:0]   mem_req_addr,
    output logic            mem_req_half,
    input  logic            mem_resp_valid,
    input  logic [ILEN-1:0] mem_resp_data,
    output logic            fill_en,
    output logic [AW-1:0]   fill_addr,
    output logic [ILEN-1:0] fill_data,
    output logic            rsp_valid,
    output logic [ILEN-1:0] rsp_insn,
    output logic            rsp_len16,
    output logic            rsp_misalign,
    output logic            rsp_fault
);

    fetch_state_e    state_q, state_d;
    logic [AW-1:0]   vaddr_q;
    logic [AW-1:0]   paddr_q;
    logic [ILEN-1:0] insn_q;
    logic            misal_q;
    logic            fault_q;
    logic            drop_fill_q;
    logic            req_fire;
    logic            in_xl;
    logic            trap;

    assign req_fire = req_valid && req_ready;
    assign in_xl    = (state_q == S_XL_WORD) || (state_q == S_XL_LO) || (state_q == S_XL_HI);

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= S_IDLE;
        else        state_q <= state_d;
    end

    // transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE: begin
                if (req_fire) begin
                    unique case (req_path)
                        P_WORD:     state_d = hit ? S_RESP : S_XL_WORD;
                        P_SPLIT:    state_d = S_XL_LO;
                        default:    state_d = S_RESP;
                    endcase
                end
            end
            S_XL_WORD: if (xl_resp_valid) state_d = xl_resp_fault ? S_RESP : S_RD_WORD;
            S_RD_WORD: if (mem_resp_valid) state_d = S_RESP;
            S_XL_LO:   if (xl_resp_valid) state_d = xl_resp_fault ? S_RESP : S_RD_LO;
            S_RD_LO: begin
                if (mem_resp_valid) begin
                    state_d = half_is_short(mem_resp_data[HLEN-1:0]) ? S_RESP : S_XL_HI;
                end
            end
            S_XL_HI:   if (xl_resp_valid) state_d = xl_resp_fault ? S_RESP : S_RD_HI;
            S_RD_HI:   if (mem_resp_valid) state_d = S_RESP;
            S_RESP:    state_d = S_IDLE;
            default:   state_d = S_IDLE;
        endcase
    end

    // datapath registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vaddr_q     <= '0;
            paddr_q     <= '0;
            insn_q      <= '0;
            misal_q     <= 1'b0;
            fault_q     <= 1'b0;
            drop_fill_q <= 1'b0;
        end else begin
            if (req_fire) begin
                vaddr_q     <= req_addr;
                misal_q     <= (req_path == P_MISALIGN);
                fault_q     <= 1'b0;
                insn_q      <= (req_path == P_WORD && hit) ? hit_data : '0;
                drop_fill_q <= 1'b0;
            end else if (flush && state_q != S_IDLE) begin
                drop_fill_q <= 1'b1;
            end
            if (in_xl && xl_resp_valid) begin
                paddr_q <= xl_resp_paddr;
                fault_q <= xl_resp_fault;
            end
            if (mem_resp_valid) begin
                unique case (state_q)
                    S_RD_WORD: insn_q <= mem_resp_data;
                    S_RD_LO:   insn_q <= {{(ILEN-HLEN){1'b0}}, mem_resp_data[HLEN-1:0]};
                    S_RD_HI:   insn_q[ILEN-1:HLEN] <= mem_resp_data[HLEN-1:0];
                    default:   ;
                endcase
            end
        end
    end

    // outputs
    always_comb begin
        req_ready     = 1'b0;
        xl_req_valid  = 1'b0;
        xl_req_vaddr  = vaddr_q;
        mem_req_valid = 1'b0;
        mem_req_addr  = paddr_q;
        mem_req_half  = 1'b0;
        rsp_valid     = 1'b0;
        unique case (state_q)
            S_IDLE:    req_ready = !flush;
            S_XL_WORD,
            S_XL_LO:   xl_req_valid = 1'b1;
            S_XL_HI: begin
                xl_req_valid = 1'b1;
                xl_req_vaddr = vaddr_q + AW'(2);
            end
            S_RD_WORD: mem_req_valid = 1'b1;
            S_RD_LO,
            S_RD_HI: begin
                mem_req_valid = 1'b1;
                mem_req_half  = 1'b1;
            end
            S_RESP:    rsp_valid = 1'b1;
            default:   ;
        endcase
    end

    assign trap         = misal_q || fault_q;
    assign rsp_insn     = trap ? '0 : insn_q;
    assign rsp_len16    = !trap && half_is_short(insn_q[HLEN-1:0]);
    assign rsp_misalign = misal_q;
    assign rsp_fault    = fault_q;

    assign fill_en   = (state_q == S_RD_WORD) && mem_resp_valid && !drop_fill_q && !flush;
    assign fill_addr = vaddr_q;
    assign fill_data = mem_resp_data;

endmodule

// File: rtl/insn_fetch_unit.sv
module insn_fetch_unit
    import ifu_pkg::*;
#(
    parameter int AW      = 32,
    parameter int ENTRIES = 32
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            flush,
    input  logic            req_valid,
    output logic            req_ready,
    input  logic [AW-1:0]   req_addr,
    input  logic            req_cmp_en,
    output logic            xl_req_valid,
    output logic [AW-1:0]   xl_req_vaddr,
    input  logic            xl_resp_valid,
    input  logic [AW-1:0]   xl_resp_paddr,
    input  logic            xl_resp_fault,
    output logic            mem_req_valid,
    output logic [AW-1:0]   mem_req_addr,
    output logic            mem_req_half,
    input  logic            mem_resp_valid,
    input  logic [ILEN-1:0] mem_resp_data,
    output logic            rsp_valid,
    output logic [ILEN-1:0] rsp_insn,
    output logic            rsp_len16,
    output logic            rsp_misalign,
    output logic            rsp_fault
);

    fetch_path_e     path;
    logic            cache_hit;
    logic [ILEN-1:0] cache_data;
    logic            fill_en;
    logic [AW-1:0]   fill_addr;
    logic [ILEN-1:0] fill_data;

    ifu_path_sel u_path (
        .low_bits (req_addr[1:0]),
        .cmp_en   (req_cmp_en),
        .path     (path)
    );

    ifu_word_store #(.AW(AW), .ENTRIES(ENTRIES)) u_store (
        .clk       (clk),
        .rst_n     (rst_n),
        .flush     (flush),
        .lk_addr   (req_addr),
        .hit       (cache_hit),
        .hit_data  (cache_data),
        .fill_en   (fill_en),
        .fill_addr (fill_addr),
        .fill_data (fill_data)
    );

    ifu_ctrl #(.AW(AW)) u_ctrl (
        .clk            (clk),
        .rst_n          (rst_n),
        .flush          (flush),
        .req_valid      (req_valid),
        .req_ready      (req_ready),
        .req_addr       (req_addr),
        .req_path       (path),
        .hit            (cache_hit),
        .hit_data       (cache_data),
        .xl_req_valid   (xl_req_valid),
        .xl_req_vaddr   (xl_req_vaddr),
        .xl_resp_valid  (xl_resp_valid),
        .xl_resp_paddr  (xl_resp_paddr),
        .xl_resp_fault  (xl_resp_fault),
        .mem_req_valid  (mem_req_valid),
        .mem_req_addr   (mem_req_addr),
        .mem_req_half   (mem_req_half),
        .mem_resp_valid (mem_resp_valid),
        .mem_resp_data  (mem_resp_data),
        .fill_en        (fill_en),
        .fill_addr      (fill_addr),
        .fill_data      (fill_data),
        .rsp_valid      (rsp_valid),
        .rsp_insn       (rsp_insn),
        .rsp_len16      (rsp_len16),
        .rsp_misalign   (rsp_misalign),
        .rsp_fault      (rsp_fault)
    );

endmodule

// File: rtl/ifu_checker.sv
module ifu_checker #(
    parameter int AW = 32
) (
    input logic          clk,
    input logic          rst_n,
    input logic          flush,
    input logic          req_valid,
    input logic          req_ready,
    input logic [AW-1:0] req_addr,
    input logic          req_cmp_en,
    input logic          cache_hit,
    input logic          xl_req_valid,
    input logic [AW-1:0] xl_req_vaddr,
    input logic          xl_resp_valid,
    input logic          xl_resp_fault,
    input logic          mem_req_valid,
    input logic [AW-1:0] mem_req_addr,
    input logic          mem_req_half,
    input logic          mem_resp_valid,
    input logic          rsp_valid,
    input logic [31:0]   rsp_insn,
    input logic          rsp_len16,
    input logic          rsp_misalign,
    input logic          rsp_fault
);

    logic fire;
    assign fire = req_valid && req_ready;

    AST_FLUSH_BLOCKS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        flush |-> !req_ready); // R1

    AST_MISALIGN_TRAP: assert property (@(posedge clk) disable iff (!rst_n)
        (fire && (req_addr[0] || (req_addr[1] && !req_cmp_en)))
        |=> (rsp_valid && rsp_misalign && rsp_insn == 32'h0)); // R2

    AST_HIT_NEXT_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        (fire && cache_hit) |=> (rsp_valid && !rsp_fault && !rsp_misalign)); // R3

    AST_HIT_ONLY_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
        cache_hit |-> (req_addr[1:0] == 2'b00)); // R3

    AST_TRAP_NO_LEN: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && (rsp_fault || rsp_misalign)) |-> (!rsp_len16 && rsp_insn == 32'h0)); // R7

    AST_FAULT_STOPS: assert property (@(posedge clk) disable iff (!rst_n)
        (xl_req_valid && xl_resp_valid && xl_resp_fault) |=> (!mem_req_valid && rsp_valid && rsp_fault)); // R8

    AST_FLUSH_MISSES: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(flush) && fire) |-> !cache_hit); // R9

    AST_XL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (xl_req_valid && !xl_resp_valid) |=> (xl_req_valid && $stable(xl_req_vaddr))); // R10

    AST_MEM_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_valid && !mem_resp_valid)
        |=> (mem_req_valid && $stable(mem_req_addr) && $stable(mem_req_half))); // R10

    AST_PORTS_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
        !(xl_req_valid && mem_req_valid)); // R10

    AST_RSP_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> !rsp_valid); // R10

endmodule

bind insn_fetch_unit ifu_checker #(.AW(AW)) u_ifu_checker (
    .clk            (clk),
    .rst_n          (rst_n),
    .flush          (flush),
    .req_valid      (req_valid),
    .req_ready      (req_ready),
    .req_addr       (req_addr),
    .req_cmp_en     (req_cmp_en),
    .cache_hit      (cache_hit),
    .xl_req_valid   (xl_req_valid),
    .xl_req_vaddr   (xl_req_vaddr),
    .xl_resp_valid  (xl_resp_valid),
    .xl_resp_fault  (xl_resp_fault),
    .mem_req_valid  (mem_req_valid),
    .mem_req_addr   (mem_req_addr),
    .mem_req_half   (mem_req_half),
    .mem_resp_valid (mem_resp_valid),
    .rsp_valid      (rsp_valid),
    .rsp_insn       (rsp_insn),
    .rsp_len16      (rsp_len16),
    .rsp_misalign   (rsp_misalign),
    .rsp_fault      (rsp_fault)
);

// File: tb/insn_fetch_unit_bench.sv
module insn_fetch_unit_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        flush = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [31:0] req_addr = '0;
    logic        req_cmp_en = 1'b0;
    logic        xl_req_valid;
    logic [31:0] xl_req_vaddr;
    logic        xl_resp_valid = 1'b0;
    logic [31:0] xl_resp_paddr = '0;
    logic        xl_resp_fault = 1'b0;
    logic        mem_req_valid;
    logic [31:0] mem_req_addr;
    logic        mem_req_half;
    logic        mem_resp_valid = 1'b0;
    logic [31:0] mem_resp_data = '0;
    logic        rsp_valid;
    logic [31:0] rsp_insn;
    logic        rsp_len16;
    logic        rsp_misalign;
    logic        rsp_fault;

    int checks = 0;
    int fails  = 0;
    int xl_n   = 0;
    int mem_n  = 0;
    int xl_wait  = 0;
    int mem_wait = 0;
    logic [31:0] mtag [32];

    always #10ns clk = ~clk;

    insn_fetch_unit u_insn_fetch_unit (
        .clk(clk), .rst_n(rst_n), .flush(flush),
        .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr), .req_cmp_en(req_cmp_en),
        .xl_req_valid(xl_req_valid), .xl_req_vaddr(xl_req_vaddr), .xl_resp_valid(xl_resp_valid),
        .xl_resp_paddr(xl_resp_paddr), .xl_resp_fault(xl_resp_fault),
        .mem_req_valid(mem_req_valid), .mem_req_addr(mem_req_addr), .mem_req_half(mem_req_half),
        .mem_resp_valid(mem_resp_valid), .mem_resp_data(mem_resp_data),
        .rsp_valid(rsp_valid), .rsp_insn(rsp_insn), .rsp_len16(rsp_len16),
        .rsp_misalign(rsp_misalign), .rsp_fault(rsp_fault)
    );

    // environment models
    function automatic logic [31:0] map_pa(input logic [31:0] v);
        return v ^ 32'h0001_0000;
    endfunction

    function automatic bit map_fault(input logic [31:0] v);
        return v[31:28] == 4'hF;
    endfunction

    function automatic logic [15:0] mem_half(input logic [31:0] a);
        return {a[17:4] ^ a[31:18], (a[2] == a[3]) ? 2'b11 : 2'b01};
    endfunction

    always @(negedge clk) begin
        if (!rst_n) begin
            xl_resp_valid  = 1'b0;
            mem_resp_valid = 1'b0;
        end else begin
            if (xl_resp_valid) begin
                xl_resp_valid = 1'b0;
            end else if (xl_req_valid) begin
                if (xl_wait == 0) begin
                    xl_resp_valid = 1'b1;
                    xl_resp_paddr = map_pa(xl_req_vaddr);
                    xl_resp_fault = map_fault(xl_req_vaddr);
                    xl_n++;
                    xl_wait = $urandom % 3;
                end else begin
                    xl_wait--;
                end
            end
            if (mem_resp_valid) begin
                mem_resp_valid = 1'b0;
            end else if (mem_req_valid) begin
                if (mem_wait == 0) begin
                    mem_resp_valid = 1'b1;
                    mem_resp_data  = mem_req_half ? {16'h0, mem_half(mem_req_addr)}
                                                  : {mem_half(mem_req_addr + 32'd2), mem_half(mem_req_addr)};
                    mem_n++;
                    mem_wait = $urandom % 3;
                end else begin
                    mem_wait--;
                end
            end
        end
    end

    task automatic chk(input bit ok, input string rq, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %h expected %h", rq, what, act, exp);
        end
    endtask

    task automatic flush_idle();
        @(negedge clk);
        flush = 1'b1;
        #1;
        chk(req_ready == 1'b0, "R1", "ready during flush", 32'(req_ready), 32'h0);
        @(negedge clk);
        flush = 1'b0;
        for (int i = 0; i < 32; i++) mtag[i] = '0;
    endtask

    task automatic do_fetch(input logic [31:0] a, input bit c, input bit mid_flush);
        bit e_mis = 0, e_flt = 0, e_hit = 0, e_fill = 0, e_len, mid;
        logic [31:0] e_insn = '0;
        logic [15:0] lo;
        int e_xl = 0, e_mem = 0, xl0, mem0, lat;
        int idx = int'(a[6:2]);
        string rq;
        if (a[1:0] == 2'b00) begin
            rq = "R4";
            if (mtag[idx] == (a | 32'h1)) begin
                e_hit = 1; rq = "R3";
                e_insn = {mem_half(map_pa(a) + 32'd2), mem_half(map_pa(a))};
            end else if (map_fault(a)) begin
                e_flt = 1; e_xl = 1; rq = "R8";
            end else begin
                e_insn = {mem_half(map_pa(a) + 32'd2), mem_half(map_pa(a))};
                e_xl = 1; e_mem = 1; e_fill = 1;
            end
        end else if (a[1:0] == 2'b10 && c) begin
            rq = "R6";
            if (map_fault(a)) begin
                e_flt = 1; e_xl = 1; rq = "R8";
            end else begin
                lo = mem_half(map_pa(a));
                if (lo[1:0] != 2'b11) begin
                    e_insn = {16'h0, lo}; e_xl = 1; e_mem = 1;
                end else if (map_fault(a + 32'd2)) begin
                    e_flt = 1; e_xl = 2; e_mem = 1; rq = "R8";
                end else begin
                    e_insn = {mem_half(map_pa(a + 32'd2)), lo}; e_xl = 2; e_mem = 2;
                end
            end
        end else begin
            e_mis = 1; rq = "R2";
        end
        e_len = !e_mis && !e_flt && (e_insn[1:0] != 2'b11);
        mid = mid_flush && (e_xl > 0);

        @(negedge clk);
        req_valid = 1'b1; req_addr = a; req_cmp_en = c;
        xl0 = xl_n; mem0 = mem_n;
        @(posedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        lat = 1;
        while (!rsp_valid && lat < 200) begin
            flush = (mid && lat == 1);
            @(negedge clk);
            lat++;
        end
        flush = 1'b0;

        chk(rsp_valid == 1'b1, rq, "response seen", 32'(rsp_valid), 32'h1);
        if (e_hit || e_mis) chk(lat == 1, rq, "one-cycle latency", 32'(lat), 32'h1);
        chk(rsp_insn == e_insn, rq, "insn", rsp_insn, e_insn);
        chk(rsp_misalign == e_mis, "R2", "misalign flag", 32'(rsp_misalign), 32'(e_mis));
        chk(rsp_fault == e_flt, "R8", "fault flag", 32'(rsp_fault), 32'(e_flt));
        chk(rsp_len16 == e_len, "R7", "length flag", 32'(rsp_len16), 32'(e_len));
        chk((xl_n - xl0) == e_xl, rq, "translations used", 32'(xl_n - xl0), 32'(e_xl));
        chk((mem_n - mem0) == e_mem, rq, "memory reads used", 32'(mem_n - mem0), 32'(e_mem));

        if (mid) for (int i = 0; i < 32; i++) mtag[i] = '0;
        else if (e_fill) mtag[idx] = a | 32'h1;
        @(negedge clk);
    endtask

    initial begin
        #(20ns * 150000);
        checks++; fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        void'($urandom(32'd4711));
        for (int i = 0; i < 32; i++) mtag[i] = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(req_ready == 1'b1, "R1", "ready after reset", 32'(req_ready), 32'h1);
        chk(rsp_valid == 1'b0, "R10", "no response after reset", 32'(rsp_valid), 32'h0);
        chk(!xl_req_valid && !mem_req_valid, "R10", "ports idle after reset",
            32'({xl_req_valid, mem_req_valid}), 32'h0);

        // R9: cleared tags never match address 0 (tag would be 1)
        do_fetch(32'h0000_0000, 1'b0, 1'b0);
        // R5: fill then hit, then aliasing eviction
        do_fetch(32'h0000_0040, 1'b0, 1'b0);
        do_fetch(32'h0000_0040, 1'b0, 1'b0);
        do_fetch(32'h0000_00C0, 1'b0, 1'b0);
        do_fetch(32'h0000_0040, 1'b0, 1'b0);
        do_fetch(32'h0000_0044, 1'b1, 1'b0);
        do_fetch(32'h0000_0044, 1'b1, 1'b0);
        // R6: two-half and short split fetches, no fill
        do_fetch(32'h0000_0102, 1'b1, 1'b0);
        do_fetch(32'h0000_0102, 1'b1, 1'b0);
        do_fetch(32'h0000_0100, 1'b1, 1'b0);
        do_fetch(32'h0000_0106, 1'b1, 1'b0);
        // R2: misaligned forms
        do_fetch(32'h0000_0101, 1'b1, 1'b0);
        do_fetch(32'h0000_0102, 1'b0, 1'b0);
        do_fetch(32'h0000_0103, 1'b1, 1'b0);
        // R8: faults on word, low half, high half; fault not stored
        do_fetch(32'hF000_0000, 1'b0, 1'b0);
        do_fetch(32'hF000_0000, 1'b0, 1'b0);
        do_fetch(32'hF000_0002, 1'b1, 1'b0);
        do_fetch(32'hEFFF_FFFE, 1'b1, 1'b0);
        // R9: flush at idle and during a miss
        flush_idle();
        do_fetch(32'h0000_0040, 1'b0, 1'b0);
        do_fetch(32'h0000_0200, 1'b0, 1'b1);
        do_fetch(32'h0000_0200, 1'b0, 1'b0);
        do_fetch(32'h0000_0200, 1'b0, 1'b0);

        for (int n = 0; n < 300; n++) begin
            logic [31:0] a;
            a = ((($urandom % 8) == 0) ? 32'hF000_0000 : 32'h0) | ($urandom & 32'h0000_01FF);
            if (($urandom % 25) == 0) flush_idle();
            do_fetch(a, 1'($urandom % 2), (($urandom % 15) == 0));
        end

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule